// File: doc/BRIEF.md
# Dual-Lane Significand Multiplier

This block multiplies unsigned significands for a fused multiply-add datapath. A mode input chooses how one shared partial-product array is used. In wide mode the array forms a single 53×53-bit product. In split mode it forms two independent 24×24-bit products side by side. Split mode works by zeroing every partial product whose two operand bits come from different lanes. No second array is instantiated.

Partial-product rows are reduced by a tree of 4-2 compressor rows down to two rows. These two rows are held in a pipeline register. A carry-propagate adder then resolves them in the next stage, and its result is registered onto the product bus. The block drops into a two-cycle slot of a three-stage multiply-add pipeline.

Top module: `mm_simd_mult`

## Requirements
- R1: With `mode_i` = 0 (wide), `prod_o` equals the full 106-bit unsigned product `a_i * b_i`.
- R2: With `mode_i` = 1 (split), `prod_o[47:0]` equals `a_i[23:0] * b_i[23:0]`.
- R3: With `mode_i` = 1, `prod_o[105:58]` equals `a_i[52:29] * b_i[52:29]`.
- R4: With `mode_i` = 1, `prod_o[57:48]` is zero.
- R5: With `mode_i` = 1, operand bits `[28:24]` of both inputs have no effect on `prod_o`.
- R6: With `mode_i` = 1, changing only the upper-lane operand fields leaves `prod_o[47:0]` unchanged.
- R7: Latency is two clock cycles. Inputs sampled at one rising edge appear on `prod_o` after the following rising edge, and `prod_o` does not change in between.
- R8: While `rst_ni` is low, `prod_o` is zero.
- R9: All-ones operands give the exact maximal products in both modes. No carry leaves bit 105 anywhere in the reduction tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = one wide product, 1 = two split-lane products |
| a_i | input | 53 | Multiplicand significand |
| b_i | input | 53 | Multiplier significand |
| prod_o | output | 106 | Registered product bus |

## Verification
A wrong lane mask in the array shows up in split mode as non-zero bits in the gap field, or as a lane result that includes cross terms. Such an error is visible on the product two cycles after the offending operands arrive. The one-hot operand sweep places a single partial product at every row and column in both modes, so each misplaced or wrongly suppressed term shows up in isolation. A wiring fault in the compressor tree or the adder corrupts the wide product on the same two-cycle schedule. The bound overflow check flags any carry that a row pushes past the top column in the very cycle it occurs.

// File: rtl/mm_simd_pkg.sv
package mm_simd_pkg;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } mm_mode_e;

  // first node index of tree level lvl when each level halves the row count
  function automatic int node_off(input int rows, input int lvl);
    return 2 * rows - 2 * (rows >> lvl);
  endfunction

  // true when bit i of a and bit j of b belong to the same split lane
  function automatic bit same_lane(input int i, input int j, input int lane_w,
                                   input int hi_lsb);
    bit lo_pair;
    bit hi_pair;
    lo_pair = (i < lane_w) && (j < lane_w);
    hi_pair = (i >= hi_lsb) && (i < hi_lsb + lane_w) &&
              (j >= hi_lsb) && (j < hi_lsb + lane_w);
    return lo_pair || hi_pair;
  endfunction

endpackage

// File: rtl/mm_c42_cell.sv
module mm_c42_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  input  logic cin_i,
  output logic sum_o,
  output logic carry_o,
  output logic cout_o
);
  logic s1;

  assign s1      = a_i ^ b_i ^ c_i;
  // cout does not depend on cin, so the lateral chain never ripples
  assign cout_o  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign sum_o   = s1 ^ d_i ^ cin_i;
  assign carry_o = (s1 & d_i) | (s1 & cin_i) | (d_i & cin_i);
endmodule

// File: rtl/mm_c42_row.sv
module mm_c42_row #(
  parameter int W = 106
) (
  input  logic [W-1:0] in0_i,
  input  logic [W-1:0] in1_i,
  input  logic [W-1:0] in2_i,
  input  logic [W-1:0] in3_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o,
  output logic         ovf_o
);
  logic [W-1:0] cy;
  logic [W-1:0] co;
  logic [W-1:0] ci;

  assign ci = {co[W-2:0], 1'b0};

  for (genvar k = 0; k < W; k++) begin : g_col
    mm_c42_cell u_cell (
      .a_i    (in0_i[k]),
      .b_i    (in1_i[k]),
      .c_i    (in2_i[k]),
      .d_i    (in3_i[k]),
      .cin_i  (ci[k]),
      .sum_o  (sum_o[k]),
      .carry_o(cy[k]),
      .cout_o (co[k])
    );
  end

  assign carry_o = {cy[W-2:0], 1'b0};
  // weight-W bits dropped here; must be zero for a bounded product
  assign ovf_o   = cy[W-1] | co[W-1];
endmodule

// File: rtl/mm_c42_tree.sv
module mm_c42_tree #(
  parameter int ROWS = 64,
  parameter int W    = 106,
  localparam int LEVELS = $clog2(ROWS) - 1,
  localparam int N_CMP  = ROWS / 2 - 1,
  localparam int NODES  = 2 * ROWS - 2
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o,
  output logic [N_CMP-1:0]       ovf_o
);
  import mm_simd_pkg::*;

  logic [W-1:0] nodes [NODES];

  for (genvar r = 0; r < ROWS; r++) begin : g_leaf
    assign nodes[r] = rows_i[r];
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int IN_OFF  = node_off(ROWS, l - 1);
    localparam int OUT_OFF = node_off(ROWS, l);
    localparam int GROUPS  = (ROWS >> l) / 2;
    localparam int C_BASE  = ROWS / 2 - (ROWS >> (l - 1)) / 2 * 1 - 0;
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      mm_c42_row #(.W(W)) u_row (
        .in0_i  (nodes[IN_OFF + 4*g]),
        .in1_i  (nodes[IN_OFF + 4*g + 1]),
        .in2_i  (nodes[IN_OFF + 4*g + 2]),
        .in3_i  (nodes[IN_OFF + 4*g + 3]),
        .sum_o  (nodes[OUT_OFF + 2*g]),
        .carry_o(nodes[OUT_OFF + 2*g + 1]),
        .ovf_o  (ovf_o[C_BASE + g])
      );
    end
  end

  assign sum_o   = nodes[NODES - 2];
  assign carry_o = nodes[NODES - 1];
endmodule

// File: rtl/mm_pp_gen.sv
module mm_pp_gen #(
  parameter int OP_W      = 53,
  parameter int LANE_W    = 24,
  parameter int LANE1_LSB = 29,
  parameter int ROWS      = 64,
  localparam int PW = 2 * OP_W
) (
  input  logic [OP_W-1:0]         a_i,
  input  logic [OP_W-1:0]         b_i,
  input  logic                    split_i,
  output logic [ROWS-1:0][PW-1:0] rows_o
);
  import mm_simd_pkg::*;

  always_comb begin
    rows_o = '0;
    for (int j = 0; j < OP_W; j++) begin
      for (int i = 0; i < OP_W; i++) begin
        rows_o[j][i+j] = a_i[i] & b_i[j] &
                         (~split_i | same_lane(i, j, LANE_W, LANE1_LSB));
      end
    end
  end
endmodule

// File: rtl/mm_cpa.sv
module mm_cpa #(
  parameter int W = 106
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = x_i + y_i;
endmodule

// File: rtl/mm_simd_mult.sv
module mm_simd_mult #(
  parameter int OP_W      = 53,
  parameter int LANE_W    = 24,
  parameter int LANE1_LSB = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o
);
  import mm_simd_pkg::*;

  localparam int PW      = 2 * OP_W;
  localparam int PP_ROWS = 1 << $clog2(OP_W);
  localparam int N_CMP   = PP_ROWS / 2 - 1;

  mm_mode_e                 mode;
  logic [PP_ROWS-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]            tree_sum;
  logic [PW-1:0]            tree_carry;
  logic [N_CMP-1:0]         tree_ovf;
  logic [PW-1:0]            s1_sum_q;
  logic [PW-1:0]            s1_carry_q;
  logic [PW-1:0]            cpa_sum;

  assign mode = mm_mode_e'(mode_i);

  mm_pp_gen #(
    .OP_W     (OP_W),
    .LANE_W   (LANE_W),
    .LANE1_LSB(LANE1_LSB),
    .ROWS     (PP_ROWS)
  ) u_pp (
    .a_i    (a_i),
    .b_i    (b_i),
    .split_i(mode == MODE_SPLIT),
    .rows_o (pp_rows)
  );

  mm_c42_tree #(
    .ROWS(PP_ROWS),
    .W   (PW)
  ) u_tree (
    .rows_i (pp_rows),
    .sum_o  (tree_sum),
    .carry_o(tree_carry),
    .ovf_o  (tree_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_sum_q   <= '0;
      s1_carry_q <= '0;
    end else begin
      s1_sum_q   <= tree_sum;
      s1_carry_q <= tree_carry;
    end
  end

  mm_cpa #(.W(PW)) u_cpa (
    .x_i  (s1_sum_q),
    .y_i  (s1_carry_q),
    .sum_o(cpa_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= cpa_sum;
  end
endmodule

// File: rtl/mm_simd_mult_chk.sv
module mm_simd_mult_chk #(
  parameter int OP_W      = 53,
  parameter int LANE_W    = 24,
  parameter int LANE1_LSB = 29,
  localparam int PW    = 2 * OP_W,
  localparam int LP    = 2 * LANE_W,
  localparam int N_CMP = (1 << $clog2(OP_W)) / 2 - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic [PW-1:0]     prod_o,
  input logic [N_CMP-1:0]  tree_ovf_i
);
  logic [1:0]    warm_q;
  logic          warm;
  logic [PW-1:0] wide_ref;
  logic [LP-1:0] lo_ref;
  logic [LP-1:0] hi_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end
  assign warm = (warm_q == 2'd2);

  assign wide_ref = PW'(a_i) * PW'(b_i);
  assign lo_ref   = LP'(a_i[LANE_W-1:0]) * LP'(b_i[LANE_W-1:0]);
  assign hi_ref   = LP'(a_i[LANE1_LSB+LANE_W-1:LANE1_LSB]) *
                    LP'(b_i[LANE1_LSB+LANE_W-1:LANE1_LSB]);

  AST_WIDE_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(mode_i, 2)) |-> prod_o == $past(wide_ref, 2)); // R1
  AST_LANE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(mode_i, 2)) |-> prod_o[LP-1:0] == $past(lo_ref, 2)); // R2
  AST_LANE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(mode_i, 2)) |-> prod_o[2*LANE1_LSB+LP-1:2*LANE1_LSB] == $past(hi_ref, 2)); // R3
  AST_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(mode_i, 2)) |-> prod_o[2*LANE1_LSB-1:LP] == '0); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |=> prod_o == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tree_ovf_i == '0); // R9
endmodule

bind mm_simd_mult mm_simd_mult_chk #(
  .OP_W     (OP_W),
  .LANE_W   (LANE_W),
  .LANE1_LSB(LANE1_LSB)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .prod_o    (prod_o),
  .tree_ovf_i(tree_ovf)
);

// File: tb/mm_simd_mult_test.sv
module mm_simd_mult_test;
  localparam int OW = 53;
  localparam int LW = 24;
  localparam int L1 = 29;
  localparam int PW = 2 * OW;
  localparam int LP = 2 * LW;
  localparam int HI_LSB = 2 * L1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [OW-1:0] a = '0;
  logic [OW-1:0] b = '0;
  logic [PW-1:0] prod;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mm_simd_mult uut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .mode_i(mode),
    .a_i   (a),
    .b_i   (b),
    .prod_o(prod)
  );

  function automatic logic [PW-1:0] exp_prod(input logic m, input logic [OW-1:0] x,
                                             input logic [OW-1:0] y);
    logic [PW-1:0] r;
    logic [LP-1:0] lo;
    logic [LP-1:0] hi;
    if (!m) begin
      r = PW'(x) * PW'(y);
    end else begin
      lo = LP'(x[LW-1:0]) * LP'(y[LW-1:0]);
      hi = LP'(x[L1+LW-1:L1]) * LP'(y[L1+LW-1:L1]);
      r = '0;
      r[LP-1:0] = lo;
      r[HI_LSB+LP-1:HI_LSB] = hi;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [OW-1:0] x, input logic [OW-1:0] y);
    @(negedge clk);
    mode = m;
    a = x;
    b = y;
  endtask

  task automatic run_vec(input logic m, input logic [OW-1:0] x, input logic [OW-1:0] y);
    logic [PW-1:0] e;
    drive(m, x, y);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    e = exp_prod(m, x, y);
    if (!m) begin
      chk("R1 wide", prod, e);
    end else begin
      chk("R2 lane0", PW'(prod[LP-1:0]), PW'(e[LP-1:0]));
      chk("R3 lane1", PW'(prod[HI_LSB+LP-1:HI_LSB]), PW'(e[HI_LSB+LP-1:HI_LSB]));
      chk("R4 gap", PW'(prod[HI_LSB-1:LP]), '0);
    end
  endtask

  function automatic logic [OW-1:0] rnd();
    return OW'({$urandom(), $urandom()});
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [PW-1:0] ref_lo;
    logic [PW-1:0] held;
    // R8: reset state
    @(negedge clk);
    @(negedge clk);
    chk("R8 reset", prod, '0);
    rst_n = 1'b1;

    // R1..R4: one-hot sweep over every partial-product position, both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < OW; i++) begin
        for (int j = 0; j < OW; j++) begin
          run_vec(m[0], OW'(1) << i, OW'(1) << j);
        end
      end
    end

    // R9: all-ones corners
    run_vec(1'b0, '1, '1);
    chk("R9 wide max", prod, PW'(PW'({OW{1'b1}}) * PW'({OW{1'b1}})));
    run_vec(1'b1, '1, '1);
    chk("R9 split max", prod, exp_prod(1'b1, '1, '1));

    // random vectors, both modes
    for (int k = 0; k < 300; k++) begin
      run_vec(1'b0, rnd(), rnd());
      run_vec(1'b1, rnd(), rnd());
    end

    // R5: middle bits ignored in split mode
    run_vec(1'b1, 53'h0_0000_00AB_CDEF, 53'h0_0000_0012_3456);
    held = prod;
    run_vec(1'b1, 53'h0_0000_1FAB_CDEF | (OW'(5'h1F) << LW),
                  53'h0_0000_0012_3456 | (OW'(5'h1F) << LW));
    chk("R5 ignored bits", prod, held);

    // R6: lane independence
    run_vec(1'b1, {24'h123456, 5'h0, 24'hFEDCBA}, {24'h000001, 5'h0, 24'h0F0F0F});
    ref_lo = PW'(prod[LP-1:0]);
    run_vec(1'b1, {24'hFFFFFF, 5'h0, 24'hFEDCBA}, {24'hABCDEF, 5'h0, 24'h0F0F0F});
    chk("R6 lane0 held", PW'(prod[LP-1:0]), ref_lo);

    // R7: two-cycle latency
    run_vec(1'b0, 53'h1F_FFFF_0000_1234, 53'h00_0ABC_DEF0_0001);
    held = prod;
    drive(1'b0, 53'h0A_5A5A_5A5A_5A5A, 53'h15_A5A5_A5A5_A5A5);
    @(posedge clk);
    @(negedge clk);
    chk("R7 one edge", prod, held);
    @(posedge clk);
    @(negedge clk);
    chk("R7 two edges", prod, exp_prod(1'b0, 53'h0A_5A5A_5A5A_5A5A, 53'h15_A5A5_A5A5_A5A5));

    // R8: mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid reset", prod, '0);
    rst_n = 1'b1;
    run_vec(1'b1, '1, 53'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule